// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is a free-running 8-bit counter driven through a clock divider. It has two compare channels, and each channel drives one waveform pin. A small register port sets the count, the two compare values, the counting mode, the divider choice and what each pin does on a match. The same port reads back the count, the settings and three event flags.

Four counting modes are available:

- **Plain up-counting** wraps from 255 to 0.
- **Clear-on-match** restarts the count after it reaches the channel A compare value.
- **Sawtooth PWM** sets a pin at the bottom of the ramp and clears it on a match.
- **Triangle PWM** counts up and then back down, so the pulses are centred in the period.

In both PWM modes a new compare value is held in a shadow register. It reaches the comparator only at the top of the count, so a period is never cut short.

Top module: `pwm_timer`

## Requirements
- R1: After reset the following are all 0: the count, both compare values, the control byte, the pin-action byte, all flags and both pins. The timer is stopped.
- R2: Control bits 2:0 choose the divider. Code 1 divides by 1, code 2 by 8, code 3 by 64, code 4 by 256 and code 5 by 1024. Codes 0, 6 and 7 stop counting. Any control write restarts the divider, so the first step comes N cycles after that write.
- R3: Mode 0 (control bits 5:4) counts up by one per step. The step taken at 255 gives 0 and sets the overflow flag (flag byte, bit 0).
- R4: A step taken while the count equals a channel's active compare value sets that channel's match flag. Channel A is flag bit 1 and channel B is flag bit 2.
- R5: In modes 0 and 1 a match applies the channel's 2-bit action. Code 0 holds the pin, 1 toggles it, 2 clears it and 3 sets it. Channel A's action is in bits 1:0 of the pin-action byte and channel B's is in bits 3:2.
- R6: In mode 1 the step taken at a count equal to compare A gives 0, so one cycle is compare A + 1 steps long.
- R7: Mode 2 counts 0..255 and wraps. Action code 2 sets the pin on the wrap step and clears it on the match step, so the pin is high for (compare+1) of 256 steps. Code 3 gives the complement.
- R8: In modes 2 and 3 a compare write reads back at once, but it reaches the comparator only on the step taken at 255.
- R9: Mode 3 steps down from 255 to 254 and up from 0 to 1. The overflow flag is set at the bottom turn. Action code 2 clears the pin on a match while counting up and sets it on a match while counting down.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. A flag event in the same cycle as its clear wins.
- R11: A count write takes precedence over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 count, 1 compare A, 2 compare B, 3 control, 4 pin actions, 5 flags |
| wrData | input | W | Write data |
| rdAddr | input | 3 | Read address, same map |
| rdData | output | W | Read data (combinational) |
| pinA | output | 1 | Channel A waveform |
| pinB | output | 1 | Channel B waveform |
| ovfIrq | output | 1 | Overflow flag |
| cmpAIrq | output | 1 | Channel A match flag |
| cmpBIrq | output | 1 | Channel B match flag |

## Verification
The bench builds the block with its defaults: an 8-bit count and a 10-bit divider. This keeps a full sawtooth period at 256 cycles and a full triangle period at 510 cycles. It also keeps the slowest divider, 1024, within a few thousand cycles. With these sizes every divider code can be stepped across its first tick boundary, and both PWM shapes can be walked through complete periods. Shadow-register hand-over at the top of the count can then be observed through the pin level.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {MD_NORMAL = 2'd0, MD_CTC = 2'd1, MD_FAST = 2'd2, MD_PHASE = 2'd3} tmrMode_e;

  typedef struct packed {
    logic tick;
    logic stepUp;
    logic stepDown;
    logic toZero;
    logic ovfEvt;
    logic loadCmp;
    logic bottomEvt;
    logic upPhase;
  } tmrStrb_t;

  localparam logic [2:0] ADR_CNT  = 3'd0;
  localparam logic [2:0] ADR_CMPA = 3'd1;
  localparam logic [2:0] ADR_CMPB = 3'd2;
  localparam logic [2:0] ADR_CTRL = 3'd3;
  localparam logic [2:0] ADR_ACT  = 3'd4;
  localparam logic [2:0] ADR_FLAG = 3'd5;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWr,
  input  tmrMode_e     mode,
  input  logic [2:0]   csel,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmpA,
  output tmrStrb_t     strb
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] preQ, divMask;
  logic run, tick, dirUpQ, isMax, isZero;

  always_comb begin
    run = 1'b1;
    unique case (csel)
      3'd1:    divMask = '0;
      3'd2:    divMask = PRE_W'((1 << 3) - 1);
      3'd3:    divMask = PRE_W'((1 << 6) - 1);
      3'd4:    divMask = PRE_W'((1 << 8) - 1);
      3'd5:    divMask = PRE_W'((1 << 10) - 1);
      default: begin divMask = '0; run = 1'b0; end
    endcase
  end

  assign tick   = run && ((preQ & divMask) == divMask);
  assign isMax  = (cnt == CNT_MAX);
  assign isZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)      preQ <= '0;
    else if (cfgWr) preQ <= '0;
    else if (run)   preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      dirUpQ <= 1'b1;
    else if (cfgWr) dirUpQ <= 1'b1;
    else if (tick && mode == MD_PHASE) begin
      if (dirUpQ && isMax)       dirUpQ <= 1'b0;
      else if (!dirUpQ && isZero) dirUpQ <= 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.tick    = tick;
    strb.upPhase = dirUpQ;
    unique case (mode)
      MD_NORMAL: begin
        strb.stepUp = tick;
        strb.ovfEvt = tick && isMax;
      end
      MD_CTC: begin
        if (cnt == cmpA) strb.toZero = tick;
        else begin
          strb.stepUp = tick;
          strb.ovfEvt = tick && isMax;
        end
      end
      MD_FAST: begin
        strb.stepUp    = tick;
        strb.ovfEvt    = tick && isMax;
        strb.loadCmp   = tick && isMax;
        strb.bottomEvt = tick && isMax;
      end
      MD_PHASE: begin
        if (dirUpQ) begin
          if (isMax) begin
            strb.stepDown = tick;
            strb.loadCmp  = tick;
          end else strb.stepUp = tick;
        end else begin
          if (isZero) begin
            strb.stepUp = tick;
            strb.ovfEvt = tick;
          end else strb.stepDown = tick;
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrBuf,
  input  logic         wrAct,
  input  logic         flagClr,
  input  logic [W-1:0] wrData,
  input  logic [1:0]   actIn,
  input  logic [W-1:0] cnt,
  input  tmrMode_e     mode,
  input  logic         tick,
  input  logic         loadCmp,
  input  logic         bottomEvt,
  input  logic         upPhase,
  output logic [W-1:0] bufVal,
  output logic [W-1:0] effVal,
  output logic [1:0]   actVal,
  output logic         pin,
  output logic         flag
);
  logic [W-1:0] actCmpQ;
  logic isPwm, match, pinN;

  assign isPwm  = (mode == MD_FAST) || (mode == MD_PHASE);
  assign effVal = isPwm ? actCmpQ : bufVal;
  assign match  = tick && (cnt == effVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufVal  <= '0;
      actCmpQ <= '0;
      actVal  <= '0;
      flag    <= 1'b0;
      pin     <= 1'b0;
    end else begin
      if (wrBuf) bufVal <= wrData;
      if (!isPwm || loadCmp) actCmpQ <= bufVal;
      if (wrAct) actVal <= actIn;
      if (match)        flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;
      pin <= pinN;
    end
  end

  always_comb begin
    pinN = pin;
    if (!isPwm) begin
      if (match) begin
        unique case (actVal)
          2'd1:    pinN = ~pin;
          2'd2:    pinN = 1'b0;
          2'd3:    pinN = 1'b1;
          default: pinN = pin;
        endcase
      end
    end else if (actVal[1]) begin
      if (mode == MD_FAST) begin
        if (bottomEvt)  pinN = ~actVal[0];
        else if (match) pinN = actVal[0];
      end else if (match) begin
        pinN = upPhase ? actVal[0] : ~actVal[0];
      end
    end
  end
endmodule

// File: rtl/tmr_data.sv
`timescale 1ns/1ps
module tmr_data
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [2:0]   rdAddr,
  output logic [W-1:0] rdData,
  input  tmrStrb_t     strb,
  output logic [W-1:0] cntQ,
  output tmrMode_e     modeQ,
  output logic [2:0]   cselQ,
  output logic [W-1:0] cmpActA,
  output logic         cfgWr,
  output logic [1:0]   pins,
  output logic         ovfQ,
  output logic [1:0]   mtch
);
  localparam int NCH = 2;

  logic [NCH-1:0][W-1:0] bufV, effV;
  logic [NCH-1:0][1:0]   actV;
  logic cntWr, flagWr;

  assign cntWr   = wrEn && (wrAddr == ADR_CNT);
  assign cfgWr   = wrEn && (wrAddr == ADR_CTRL);
  assign flagWr  = wrEn && (wrAddr == ADR_FLAG);
  assign cmpActA = effV[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      modeQ <= MD_NORMAL;
      cselQ <= '0;
      ovfQ  <= 1'b0;
    end else begin
      if (cntWr)              cntQ <= wrData;
      else if (strb.toZero)   cntQ <= '0;
      else if (strb.stepUp)   cntQ <= cntQ + 1'b1;
      else if (strb.stepDown) cntQ <= cntQ - 1'b1;
      if (cfgWr) begin
        modeQ <= tmrMode_e'(wrData[5:4]);
        cselQ <= wrData[2:0];
      end
      if (strb.ovfEvt)             ovfQ <= 1'b1;
      else if (flagWr && wrData[0]) ovfQ <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan #(.W(W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .wrBuf    (wrEn && (wrAddr == 3'(ADR_CMPA + g))),
      .wrAct    (wrEn && (wrAddr == ADR_ACT)),
      .flagClr  (flagWr && wrData[1+g]),
      .wrData   (wrData),
      .actIn    (wrData[2*g+1 -: 2]),
      .cnt      (cntQ),
      .mode     (modeQ),
      .tick     (strb.tick),
      .loadCmp  (strb.loadCmp),
      .bottomEvt(strb.bottomEvt),
      .upPhase  (strb.upPhase),
      .bufVal   (bufV[g]),
      .effVal   (effV[g]),
      .actVal   (actV[g]),
      .pin      (pins[g]),
      .flag     (mtch[g])
    );
  end

  always_comb begin
    unique case (rdAddr)
      ADR_CNT:  rdData = cntQ;
      ADR_CMPA: rdData = bufV[0];
      ADR_CMPB: rdData = bufV[1];
      ADR_CTRL: rdData = W'({modeQ, 1'b0, cselQ});
      ADR_ACT:  rdData = W'({actV[1], actV[0]});
      ADR_FLAG: rdData = W'({mtch, ovfQ});
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [2:0]   rdAddr,
  output logic [W-1:0] rdData,
  output logic         pinA,
  output logic         pinB,
  output logic         ovfIrq,
  output logic         cmpAIrq,
  output logic         cmpBIrq
);
  tmrStrb_t     strb;
  logic [W-1:0] cntQ, cmpActA;
  tmrMode_e     modeQ;
  logic [2:0]   cselQ;
  logic         cfgWr;
  logic [1:0]   pins, mtch;

  tmr_ctrl #(.W(W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .mode(modeQ), .csel(cselQ),
    .cnt(cntQ), .cmpA(cmpActA), .strb(strb)
  );

  tmr_data #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strb(strb), .cntQ(cntQ), .modeQ(modeQ),
    .cselQ(cselQ), .cmpActA(cmpActA), .cfgWr(cfgWr), .pins(pins), .ovfQ(ovfIrq),
    .mtch(mtch)
  );

  assign pinA    = pins[0];
  assign pinB    = pins[1];
  assign cmpAIrq = mtch[0];
  assign cmpBIrq = mtch[1];
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [2:0]   wrAddr,
  input logic [W-1:0] wrData,
  input logic [W-1:0] cntQ,
  input logic [1:0]   modeQ,
  input logic [2:0]   cselQ,
  input logic [W-1:0] cmpA,
  input logic         tick,
  input logic         ovfIrq
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic cntWr, ctrlWr, ovfClr;
  assign cntWr  = wrEn && (wrAddr == 3'd0);
  assign ctrlWr = wrEn && (wrAddr == 3'd3);
  assign ovfClr = wrEn && (wrAddr == 3'd5) && wrData[0];

  a_r2_stopped_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (cselQ == 3'd0 || cselQ > 3'd5) |-> !tick);

  a_r11_count_write: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cntQ == $past(wrData));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cntWr) |=> $stable(cntQ));

  a_r3_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd0 && tick && cntQ == CNT_MAX && !cntWr) |=> (ovfIrq && cntQ == '0));

  a_r6_ctc_restart: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd1 && tick && cntQ == cmpA && !cntWr) |=> cntQ == '0);

  a_r9_turn_at_top: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd3 && tick && cntQ == CNT_MAX && !cntWr && !ctrlWr) |=> cntQ == CNT_MAX - 1'b1);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfIrq && !ovfClr) |=> ovfIrq);
endmodule

bind pwm_timer tmr_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cntQ(cntQ), .modeQ(modeQ), .cselQ(cselQ), .cmpA(cmpActA), .tick(strb.tick),
  .ovfIrq(ovfIrq)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic pinA, pinB, ovfIrq, cmpAIrq, cmpBIrq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwm_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinA(pinA), .pinB(pinB),
    .ovfIrq(ovfIrq), .cmpAIrq(cmpAIrq), .cmpBIrq(cmpBIrq)
  );

  typedef struct packed {
    logic [2:0]  cs;
    logic [15:0] waitCyc;
    logic [7:0]  expCnt;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{3'd1, 16'd5,    8'd5},
    '{3'd2, 16'd16,   8'd2},
    '{3'd2, 16'd15,   8'd1},
    '{3'd3, 16'd64,   8'd1},
    '{3'd3, 16'd63,   8'd0},
    '{3'd4, 16'd512,  8'd2},
    '{3'd4, 16'd255,  8'd0},
    '{3'd5, 16'd1024, 8'd1},
    '{3'd5, 16'd1023, 8'd0},
    '{3'd0, 16'd40,   8'd0},
    '{3'd6, 16'd40,   8'd0},
    '{3'd7, 16'd40,   8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdv(input logic [2:0] a, output logic [7:0] v);
    rdAddr = a; #1; v = rdData; rdAddr = 3'd0;
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitCnt(input logic [7:0] v);
    logic [7:0] x;
    for (int i = 0; i < 1200; i++) begin
      rdv(3'd0, x);
      if (x == v) return;
      steps(1);
    end
    check("waitCnt", int'(x), int'(v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int hiA, hiB;
    steps(3);
    rstN = 1'b1;
    steps(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rdv(3'(a), v);
      check("R1 reg", int'(v), 0);
    end
    check("R1 pinA", int'(pinA), 0);
    check("R1 pinB", int'(pinB), 0);
    check("R1 flags", int'({cmpBIrq, cmpAIrq, ovfIrq}), 0);
    steps(5);
    rdv(3'd0, v);
    check("R1 stopped", int'(v), 0);

    // R2 divider table
    for (int i = 0; i < 12; i++) begin
      wr(3'd3, 8'd0);
      wr(3'd0, 8'd0);
      wr(3'd3, {5'd0, VEC[i].cs});
      steps(int'(VEC[i].waitCyc));
      rdv(3'd0, v);
      check($sformatf("R2 vec%0d", i), int'(v), int'(VEC[i].expCnt));
    end

    // R3 wrap and overflow
    wr(3'd3, 8'd0); wr(3'd0, 8'd250); wr(3'd5, 8'd7); wr(3'd3, 8'd1);
    steps(5); rdv(3'd0, v);
    check("R3 at 255", int'(v), 255);
    check("R3 no ovf yet", int'(ovfIrq), 0);
    steps(1); rdv(3'd0, v);
    check("R3 wrap", int'(v), 0);
    check("R3 ovf", int'(ovfIrq), 1);

    // R10 set wins over clear, then clear
    wr(3'd3, 8'd0); wr(3'd0, 8'd252); wr(3'd5, 8'd7); wr(3'd3, 8'd1);
    steps(3);
    check("R10 pre", int'(ovfIrq), 0);
    wr(3'd5, 8'd1);
    check("R10 set wins", int'(ovfIrq), 1);
    wr(3'd5, 8'd1);
    check("R10 cleared", int'(ovfIrq), 0);
    wr(3'd5, 8'd0);
    check("R10 zero write", int'(ovfIrq), 0);

    // R11 count write beats step
    wr(3'd0, 8'd200); rdv(3'd0, v);
    check("R11 written", int'(v), 200);
    steps(1); rdv(3'd0, v);
    check("R11 resumes", int'(v), 201);

    // R4 R5 match flags and pin actions
    wr(3'd3, 8'd0); wr(3'd0, 8'd0); wr(3'd1, 8'd10); wr(3'd2, 8'd20);
    wr(3'd4, 8'h0D); wr(3'd5, 8'd7); wr(3'd3, 8'd1);
    steps(10);
    check("R5 before toggle", int'(pinA), 0);
    check("R4 flagA before", int'(cmpAIrq), 0);
    steps(1);
    check("R5 toggle", int'(pinA), 1);
    check("R4 flagA", int'(cmpAIrq), 1);
    steps(10);
    check("R5 set", int'(pinB), 1);
    check("R4 flagB", int'(cmpBIrq), 1);
    wr(3'd3, 8'd0); wr(3'd0, 8'd0); wr(3'd4, 8'h02); wr(3'd3, 8'd1);
    steps(21);
    check("R5 clear", int'(pinA), 0);
    check("R5 hold", int'(pinB), 1);

    // R6 clear on compare A
    wr(3'd3, 8'd0); wr(3'd0, 8'd0); wr(3'd1, 8'd4); wr(3'd5, 8'd7); wr(3'd3, 8'h11);
    steps(4); rdv(3'd0, v);
    check("R6 reach", int'(v), 4);
    steps(1); rdv(3'd0, v);
    check("R6 restart", int'(v), 0);
    check("R6 flagA", int'(cmpAIrq), 1);
    steps(2); rdv(3'd0, v);
    check("R6 count", int'(v), 2);
    steps(3); rdv(3'd0, v);
    check("R6 period", int'(v), 0);
    steps(10);
    check("R6 no ovf", int'(ovfIrq), 0);

    // R7 sawtooth duty
    wr(3'd3, 8'd0); wr(3'd1, 8'd100); wr(3'd2, 8'd100); wr(3'd4, 8'h0E);
    wr(3'd0, 8'd255); wr(3'd3, 8'h21);
    steps(1); rdv(3'd0, v);
    check("R7 wrap", int'(v), 0);
    check("R7 set at bottom", int'(pinA), 1);
    check("R7 inverted", int'(pinB), 0);
    hiA = 0; hiB = 0;
    for (int i = 0; i < 256; i++) begin
      hiA += int'(pinA);
      hiB += int'(pinB);
      steps(1);
    end
    check("R7 duty A", hiA, 101);
    check("R7 duty B", hiB, 155);

    // R8 shadowed compare
    waitCnt(8'd5);
    wr(3'd1, 8'd50);
    rdv(3'd1, v);
    check("R8 readback", int'(v), 50);
    waitCnt(8'd60);
    check("R8 old compare active", int'(pinA), 1);
    waitCnt(8'd50);
    check("R8 before new match", int'(pinA), 1);
    steps(1);
    check("R8 new compare", int'(pinA), 0);

    // R9 triangle
    wr(3'd3, 8'd0); wr(3'd0, 8'd0); wr(3'd1, 8'd100); wr(3'd4, 8'h02); wr(3'd3, 8'h31);
    waitCnt(8'd100); steps(1);
    check("R9 up match clears", int'(pinA), 0);
    waitCnt(8'd255); steps(1); rdv(3'd0, v);
    check("R9 top turn", int'(v), 254);
    waitCnt(8'd100);
    check("R9 before down match", int'(pinA), 0);
    steps(1);
    check("R9 down match sets", int'(pinA), 1);
    wr(3'd5, 8'd7);
    waitCnt(8'd0);
    check("R9 ovf before bottom", int'(ovfIrq), 0);
    steps(1); rdv(3'd0, v);
    check("R9 bottom turn", int'(v), 1);
    check("R9 ovf at bottom", int'(ovfIrq), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule